// File: doc/BRIEF.md
# Descriptor Ring Queue Pointer Bank

This block holds the pointer and configuration registers for a bank of descriptor-ring queues. Software programs each queue over a simple register bus. It sets the location of the ring in memory, the ring's length in descriptors and a configuration word. Software then hands descriptors to the engine by writing a count to a doorbell register. The tail is never written directly. It only moves forward through the doorbell, by the number of descriptors posted.

On the engine side, a consume port names a queue and asks for one descriptor. The block grants the request in the same cycle when that queue is enabled and holds at least one posted descriptor. On a grant, the queue's head moves forward by one. Both pointers wrap at the ring length. A packed status word reports the used count, a full flag and a sticky flag that records a doorbell which tried to post more descriptors than the ring had room for. A write-only control register lets software clear individual pointers or the whole queue.

Top module: `descq_ptr_bank`

## Requirements
- R1: Queue q (0..15) owns the 0x1000-byte window starting at 0x1000*(q+1). Its registers sit at these offsets: configuration 0x20, status 0x24, ring base low 0x28, ring base high 0x2C, ring length 0x30, head 0x34, doorbell 0x38, tail 0x3C and control 0x64. Configuration, base high and length read back what was written.
- R2: After reset every register reads zero, except status, which reads 0x8000_0000 because a zero-length ring has no room.
- R3: A doorbell write advances the tail by the count in write-data bits [23:0], modulo the ring length. The upper eight bits are ignored.
- R4: When the doorbell count exceeds the free room (length−1−used, or 0 for a zero length), the tail advances only by the free room and status bit 29 is set. Bit 29 stays set until the queue is reset.
- R5: Status bits [24:0] give the used count (tail−head) mod length. Bit 31 is set when the used count equals length−1, or when the length is zero.
- R6: A consume request is granted in the same cycle only if configuration bits 16 and 17 are both set and the used count is nonzero. Each grant advances the head by one, modulo the length.
- R7: On a control write, bit 1 clears the tail, bit 2 clears the head, and bit 8 clears every register of the queue including the sticky flag. Bits 3 and 4 leave all readable state unchanged.
- R8: Ring base low keeps write-data bits [31:6]. Bits [5:0] read zero.
- R9: Writing the ring length clears both head and tail of that queue.
- R10: The doorbell and control registers read zero. Writes to status, head and tail are ignored.
- R11: Addresses below 0x1000, above queue 15's window, or at unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 17 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pop_req | input | 1 | Engine asks for one descriptor |
| pop_qid | input | 4 | Queue the engine asks from |
| pop_ack | output | 1 | Request granted; head advances at the clock edge |

## Verification
On every cycle, the assertions check these properties: head and tail stay inside the ring, a zero-length ring holds both pointers at zero, and a grant only happens for a queue holding descriptors. Each grant must move the head by exactly one with wrap. The tail must never move without a bus write, and the overflow flag must never drop without one. The following can only be shown by the bench's scenarios at the register interface, because each depends on the decoded value a particular write carries: doorbell clamping, the exact used and full encoding in the status word, the per-bit effect of the control register, the masking of the base address, and the read-as-zero and write-ignored cases.

// File: rtl/descq_pkg.sv
// Shared constants and types for the descriptor-ring pointer bank.
// Assumes 32-bit register data and 4 KiB queue windows.
package descq_pkg;
    localparam int DATA_W  = 32;
    localparam int DB_W    = 24;   // doorbell count field width
    localparam int USED_W  = 25;   // used-count field in status
    localparam int OFF_W   = 12;   // offset bits inside one queue window

    localparam logic [OFF_W-1:0] OFF_CFG  = 12'h020;
    localparam logic [OFF_W-1:0] OFF_STAT = 12'h024;
    localparam logic [OFF_W-1:0] OFF_BLO  = 12'h028;
    localparam logic [OFF_W-1:0] OFF_BHI  = 12'h02C;
    localparam logic [OFF_W-1:0] OFF_LEN  = 12'h030;
    localparam logic [OFF_W-1:0] OFF_HEAD = 12'h034;
    localparam logic [OFF_W-1:0] OFF_DB   = 12'h038;
    localparam logic [OFF_W-1:0] OFF_TAIL = 12'h03C;
    localparam logic [OFF_W-1:0] OFF_CTL  = 12'h064;

    localparam int CFG_PREF_BIT  = 16;
    localparam int CFG_SCHED_BIT = 17;
    localparam int CTL_TAIL_BIT  = 1;
    localparam int CTL_HEAD_BIT  = 2;
    localparam int CTL_QRST_BIT  = 8;
    localparam int BASE_LSB      = 6;

    // One-hot write targets inside a queue window
    typedef struct packed {
        logic cfg;
        logic blo;
        logic bhi;
        logic len;
        logic db;
        logic ctl;
    } wsel_t;

    // Readable register selected by the current address
    typedef enum logic [2:0] {
        RD_NONE, RD_CFG, RD_STAT, RD_BLO, RD_BHI, RD_LEN, RD_HEAD, RD_TAIL
    } rsel_e;
endpackage

// File: rtl/descq_decode.sv
// Address decoder: splits a bus address into a queue index and a register
// select. Assumes queue q occupies window q+1; window 0 and windows past
// NQ are unmapped and produce no hit.
module descq_decode
    import descq_pkg::*;
#(
    parameter int NQ     = 16,
    parameter int ADDR_W = 17,
    localparam int QW    = $clog2(NQ),
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [QW-1:0]     q_idx,
    output wsel_t             wsel,
    output rsel_e             rsel
);
    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;

    assign blk = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    // window index to queue index and range test
    always_comb begin
        hit   = (blk != '0) && (int'(blk) <= NQ);
        q_idx = QW'(int'(blk) - 1);
    end

    // offset to write target (only writable registers)
    always_comb begin
        wsel     = '0;
        wsel.cfg = hit && (off == OFF_CFG);
        wsel.blo = hit && (off == OFF_BLO);
        wsel.bhi = hit && (off == OFF_BHI);
        wsel.len = hit && (off == OFF_LEN);
        wsel.db  = hit && (off == OFF_DB);
        wsel.ctl = hit && (off == OFF_CTL);
    end

    // offset to read source (write-only registers fall to RD_NONE)
    always_comb begin
        rsel = RD_NONE;
        if (hit) begin
            case (off)
                OFF_CFG:  rsel = RD_CFG;
                OFF_STAT: rsel = RD_STAT;
                OFF_BLO:  rsel = RD_BLO;
                OFF_BHI:  rsel = RD_BHI;
                OFF_LEN:  rsel = RD_LEN;
                OFF_HEAD: rsel = RD_HEAD;
                OFF_TAIL: rsel = RD_TAIL;
                default:  rsel = RD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/descq_slot.sv
// State of one descriptor-ring queue: configuration, ring base, length,
// head and tail pointers and the sticky overflow flag. Assumes wsel is
// already qualified by the bus strobe and queue match, and that pop only
// arrives when ready is high. Pointers stay below len whenever len != 0.
module descq_slot
    import descq_pkg::*;
#(
    parameter int PTR_W = 24,
    localparam int CW   = ((PTR_W > DB_W) ? PTR_W : DB_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wsel_t             wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] cfg,
    output logic [DATA_W-1:BASE_LSB] base_lo,
    output logic [DATA_W-1:0] base_hi,
    output logic [PTR_W-1:0]  len,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  tail,
    output logic [PTR_W-1:0]  used,
    output logic              full,
    output logic              ovf,
    output logic              ready
);
    logic             qrst;
    logic [PTR_W-1:0] cap;
    logic [PTR_W-1:0] room;
    logic [CW-1:0]    n_c;
    logic             clamp;
    logic [PTR_W-1:0] step;
    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] tail_nx;
    logic [PTR_W:0]   hp1;
    logic [PTR_W-1:0] head_nx;

    assign qrst = wsel.ctl && wdata[CTL_QRST_BIT];

    // occupancy, capacity and full flag
    always_comb begin
        used = tail - head + ((tail < head) ? len : '0);
        cap  = (len == '0) ? '0 : len - 1'b1;
        room = cap - used;
        full = (used == cap);
    end

    // doorbell: clamp the count to the free room and wrap the new tail
    always_comb begin
        n_c     = CW'(wdata[DB_W-1:0]);
        clamp   = n_c > CW'(room);
        step    = clamp ? room : PTR_W'(wdata[DB_W-1:0]);
        sum     = {1'b0, tail} + {1'b0, step};
        tail_nx = (sum >= {1'b0, len}) ? PTR_W'(sum - {1'b0, len}) : sum[PTR_W-1:0];
    end

    // consume: head plus one with wrap
    always_comb begin
        hp1     = {1'b0, head} + 1'b1;
        head_nx = (hp1 >= {1'b0, len}) ? '0 : hp1[PTR_W-1:0];
    end

    assign ready = cfg[CFG_PREF_BIT] && cfg[CFG_SCHED_BIT] && (used != '0);

    // configuration, base and length registers
    always_ff @(posedge clk) begin
        if (!rst_n || qrst) begin
            cfg     <= '0;
            base_lo <= '0;
            base_hi <= '0;
            len     <= '0;
        end else begin
            if (wsel.cfg) cfg     <= wdata;
            if (wsel.blo) base_lo <= wdata[DATA_W-1:BASE_LSB];
            if (wsel.bhi) base_hi <= wdata;
            if (wsel.len) len     <= wdata[PTR_W-1:0];
        end
    end

    // head pointer: cleared by length write or control, else advanced by pop
    always_ff @(posedge clk) begin
        if (!rst_n || qrst || wsel.len) begin
            head <= '0;
        end else if (wsel.ctl && wdata[CTL_HEAD_BIT]) begin
            head <= '0;
        end else if (pop) begin
            head <= head_nx;
        end
    end

    // tail pointer: cleared by length write or control, else moved by doorbell
    always_ff @(posedge clk) begin
        if (!rst_n || qrst || wsel.len) begin
            tail <= '0;
        end else if (wsel.ctl && wdata[CTL_TAIL_BIT]) begin
            tail <= '0;
        end else if (wsel.db) begin
            tail <= tail_nx;
        end
    end

    // sticky overflow flag, cleared only by a queue reset
    always_ff @(posedge clk) begin
        if (!rst_n || qrst) begin
            ovf <= 1'b0;
        end else if (wsel.db && clamp) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/descq_rdmux.sv
// Read-data multiplexer: picks the register named by the decoder from the
// addressed queue and packs the status word. Unmapped and write-only
// locations return zero.
module descq_rdmux
    import descq_pkg::*;
#(
    parameter int NQ    = 16,
    parameter int PTR_W = 24,
    localparam int QW   = $clog2(NQ)
) (
    input  rsel_e                               rsel,
    input  logic [QW-1:0]                       q_idx,
    input  logic [NQ-1:0][DATA_W-1:0]           cfg_a,
    input  logic [NQ-1:0][DATA_W-1:BASE_LSB]    blo_a,
    input  logic [NQ-1:0][DATA_W-1:0]           bhi_a,
    input  logic [NQ-1:0][PTR_W-1:0]            len_a,
    input  logic [NQ-1:0][PTR_W-1:0]            head_a,
    input  logic [NQ-1:0][PTR_W-1:0]            tail_a,
    input  logic [NQ-1:0][PTR_W-1:0]            used_a,
    input  logic [NQ-1:0]                       full_a,
    input  logic [NQ-1:0]                       ovf_a,
    output logic [DATA_W-1:0]                   rdata
);
    logic [DATA_W-1:0] stat;

    // status word: full[31], overflow[29], used count in the low field
    assign stat = {full_a[q_idx], 1'b0, ovf_a[q_idx], 4'b0000, USED_W'(used_a[q_idx])};

    // select one register of the addressed queue
    always_comb begin
        case (rsel)
            RD_CFG:  rdata = cfg_a[q_idx];
            RD_STAT: rdata = stat;
            RD_BLO:  rdata = {blo_a[q_idx], {BASE_LSB{1'b0}}};
            RD_BHI:  rdata = bhi_a[q_idx];
            RD_LEN:  rdata = DATA_W'(len_a[q_idx]);
            RD_HEAD: rdata = DATA_W'(head_a[q_idx]);
            RD_TAIL: rdata = DATA_W'(tail_a[q_idx]);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/descq_ptr_bank.sv
// Top of the descriptor-ring pointer bank: decodes the register bus,
// instantiates one state slot per queue and grants engine consume
// requests. Assumes a single register access per cycle, with reads
// combinational on bus_addr and writes taking effect at the clock edge.
module descq_ptr_bank
    import descq_pkg::*;
#(
    parameter int NQ     = 16,
    parameter int PTR_W  = 24,
    parameter int ADDR_W = 17,
    localparam int QW    = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pop_req,
    input  logic [QW-1:0]     pop_qid,
    output logic              pop_ack
);
    logic        hit;
    logic [QW-1:0] q_idx;
    wsel_t       wsel;
    rsel_e       rsel;

    logic [NQ-1:0][DATA_W-1:0]        cfg_a;
    logic [NQ-1:0][DATA_W-1:BASE_LSB] blo_a;
    logic [NQ-1:0][DATA_W-1:0]        bhi_a;
    logic [NQ-1:0][PTR_W-1:0]         len_a;
    logic [NQ-1:0][PTR_W-1:0]         head_a;
    logic [NQ-1:0][PTR_W-1:0]         tail_a;
    logic [NQ-1:0][PTR_W-1:0]         used_a;
    logic [NQ-1:0]                    full_a;
    logic [NQ-1:0]                    ovf_a;
    logic [NQ-1:0]                    ready_a;

    descq_decode #(.NQ(NQ), .ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .hit   (hit),
        .q_idx (q_idx),
        .wsel  (wsel),
        .rsel  (rsel)
    );

    // grant a consume request when the named queue is ready
    assign pop_ack = pop_req && ready_a[pop_qid];

    for (genvar i = 0; i < NQ; i++) begin : g_q
        wsel_t wsel_i;
        logic  pop_i;

        // route the write strobe and the grant to this queue only
        assign wsel_i = (bus_wr && hit && (q_idx == QW'(i))) ? wsel : '0;
        assign pop_i  = pop_ack && (pop_qid == QW'(i));

        descq_slot #(.PTR_W(PTR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wsel    (wsel_i),
            .wdata   (bus_wdata),
            .pop     (pop_i),
            .cfg     (cfg_a[i]),
            .base_lo (blo_a[i]),
            .base_hi (bhi_a[i]),
            .len     (len_a[i]),
            .head    (head_a[i]),
            .tail    (tail_a[i]),
            .used    (used_a[i]),
            .full    (full_a[i]),
            .ovf     (ovf_a[i]),
            .ready   (ready_a[i])
        );
    end

    descq_rdmux #(.NQ(NQ), .PTR_W(PTR_W)) u_rd (
        .rsel   (rsel),
        .q_idx  (q_idx),
        .cfg_a  (cfg_a),
        .blo_a  (blo_a),
        .bhi_a  (bhi_a),
        .len_a  (len_a),
        .head_a (head_a),
        .tail_a (tail_a),
        .used_a (used_a),
        .full_a (full_a),
        .ovf_a  (ovf_a),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/descq_ptr_bank_chk.sv
// Checker for the pointer bank: cycle-level properties over pointer
// movement, grant legality and the sticky flag. Attached by bind.
module descq_ptr_bank_chk #(
    parameter int NQ    = 16,
    parameter int PTR_W = 24,
    parameter int QW    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    pop_req,
    input logic                    pop_ack,
    input logic [QW-1:0]           pop_qid,
    input logic [NQ-1:0][PTR_W-1:0] head_a,
    input logic [NQ-1:0][PTR_W-1:0] tail_a,
    input logic [NQ-1:0][PTR_W-1:0] len_a,
    input logic [NQ-1:0][PTR_W-1:0] used_a,
    input logic [NQ-1:0]           ovf_a
);
    function automatic logic [PTR_W-1:0] inc_wrap(logic [PTR_W-1:0] h, logic [PTR_W-1:0] l);
        logic [PTR_W:0] s;
        s = {1'b0, h} + 1'b1;
        return (s == {1'b0, l}) ? '0 : s[PTR_W-1:0];
    endfunction

    a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |-> pop_req);

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        a_r5_ptr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
            (len_a[q] != '0) |-> (head_a[q] < len_a[q]) && (tail_a[q] < len_a[q]));

        a_r9_zero_len_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
            (len_a[q] == '0) |-> (head_a[q] == '0) && (tail_a[q] == '0));

        a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_ack && pop_qid == QW'(q)) |-> (used_a[q] != '0));

        a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_ack && pop_qid == QW'(q) && !bus_wr) |=>
                (head_a[q] == inc_wrap($past(head_a[q]), $past(len_a[q]))));

        a_r3_tail_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr |=> $stable(tail_a[q]));

        a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_a[q] && !bus_wr) |=> ovf_a[q]);
    end
endmodule

bind descq_ptr_bank descq_ptr_bank_chk #(.NQ(NQ), .PTR_W(PTR_W), .QW(QW)) u_chk (.*);

// File: tb/sim_descq_ptr_bank.sv
`timescale 1ns/100ps
// Bench for the pointer bank: a vector table of register accesses,
// then directed scenarios for consume, wrap, clamp and control resets.
module sim_descq_ptr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pop_req = 1'b0;
    logic [3:0]  pop_qid = '0;
    logic        pop_ack;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    descq_ptr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pop_req(pop_req), .pop_qid(pop_qid), .pop_ack(pop_ack)
    );

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 17'h03030, 32'h0000_0008, 4'd9 },  // R9 length write on queue 2
        '{1'b0, 17'h03030, 32'h0000_0008, 4'd1 },  // R1 length reads back
        '{1'b0, 17'h03034, 32'h0000_0000, 4'd9 },  // R9 head cleared
        '{1'b1, 17'h03028, 32'hABCD_EF7F, 4'd8 },  // R8 base low write
        '{1'b0, 17'h03028, 32'hABCD_EF40, 4'd8 },  // R8 low six bits drop
        '{1'b1, 17'h0302C, 32'h0000_0012, 4'd1 },  // R1 base high
        '{1'b0, 17'h0302C, 32'h0000_0012, 4'd1 },
        '{1'b1, 17'h03038, 32'hFF00_0003, 4'd3 },  // R3 upper byte ignored
        '{1'b0, 17'h0303C, 32'h0000_0003, 4'd3 },
        '{1'b0, 17'h03024, 32'h0000_0003, 4'd5 },  // R5 used = 3
        '{1'b0, 17'h03038, 32'h0000_0000, 4'd10},  // R10 doorbell reads zero
        '{1'b1, 17'h0303C, 32'h0000_0005, 4'd10},  // R10 tail write ignored
        '{1'b0, 17'h0303C, 32'h0000_0003, 4'd10},
        '{1'b1, 17'h03034, 32'h0000_0007, 4'd10},  // R10 head write ignored
        '{1'b0, 17'h03034, 32'h0000_0000, 4'd10},
        '{1'b1, 17'h03024, 32'hFFFF_FFFF, 4'd10},  // R10 status write ignored
        '{1'b0, 17'h03024, 32'h0000_0003, 4'd10},
        '{1'b1, 17'h03038, 32'h0000_0004, 4'd5 },  // R5 fill to length-1
        '{1'b0, 17'h03024, 32'h8000_0007, 4'd5 },
        '{1'b1, 17'h03038, 32'h0000_0001, 4'd4 },  // R4 no room: clamp
        '{1'b0, 17'h03024, 32'hA000_0007, 4'd4 },
        '{1'b0, 17'h0303C, 32'h0000_0007, 4'd4 },
        '{1'b0, 17'h00030, 32'h0000_0000, 4'd11},  // R11 window 0
        '{1'b0, 17'h03050, 32'h0000_0000, 4'd11},  // R11 unmapped offset
        '{1'b0, 17'h11030, 32'h0000_0000, 4'd11},  // R11 past last queue
        '{1'b1, 17'h03020, 32'h0003_0000, 4'd6 },  // R6 enable queue 2
        '{1'b0, 17'h03020, 32'h0003_0000, 4'd1 },
        '{1'b1, 17'h10030, 32'h0000_0005, 4'd1 },  // R1 last queue window
        '{1'b0, 17'h10030, 32'h0000_0005, 4'd1 },
        '{1'b0, 17'h0F030, 32'h0000_0000, 4'd1 }   // R1 neighbour untouched
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [16:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic pop(input logic [3:0] q, input logic exp, input string tag);
        @(negedge clk);
        pop_req = 1'b1; pop_qid = q;
        #1 chk(tag, {31'b0, pop_ack}, {31'b0, exp});
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        rd(17'h01020, 32'h0, "R2 cfg");
        rd(17'h01024, 32'h8000_0000, "R2 status");
        rd(17'h0103C, 32'h0, "R2 tail");
        rd(17'h01028, 32'h0, "R2 base");

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
            else rd(TBL[i].addr, TBL[i].data, $sformatf("R%0d vec %0d", TBL[i].req, i));
        end

        // R6 drain queue 2, then refuse on empty
        for (int k = 0; k < 7; k++) pop(4'd2, 1'b1, "R6 grant");
        pop(4'd2, 1'b0, "R6 empty refused");
        rd(17'h03034, 32'h7, "R6 head");
        rd(17'h03024, 32'h2000_0000, "R4 sticky after drain");
        // R3 tail wraps past the ring end
        wr(17'h03038, 32'h3);
        rd(17'h0303C, 32'h2, "R3 tail wrap");
        rd(17'h03024, 32'h2000_0003, "R5 used across wrap");

        // R6 enable gating on queue 5
        wr(17'h06030, 32'h4);
        wr(17'h06038, 32'h2);
        wr(17'h06020, 32'h0001_0000);
        pop(4'd5, 1'b0, "R6 only prefetch");
        wr(17'h06020, 32'h0002_0000);
        pop(4'd5, 1'b0, "R6 only scheduling");
        wr(17'h06020, 32'h0003_0000);
        pop(4'd5, 1'b1, "R6 both enables");
        rd(17'h06034, 32'h1, "R6 head step");
        // R9 length rewrite clears pointers
        wr(17'h06030, 32'h6);
        rd(17'h06034, 32'h0, "R9 head");
        rd(17'h0603C, 32'h0, "R9 tail");

        // R7 control bits on queue 2 (head 7, tail 2)
        wr(17'h03064, 32'h18);
        rd(17'h0303C, 32'h2, "R7 bits 3,4 tail");
        rd(17'h03034, 32'h7, "R7 bits 3,4 head");
        wr(17'h03064, 32'h2);
        rd(17'h0303C, 32'h0, "R7 tail clear");
        rd(17'h03024, 32'h2000_0001, "R7 status after tail clear");
        wr(17'h03064, 32'h4);
        rd(17'h03034, 32'h0, "R7 head clear");
        rd(17'h03064, 32'h0, "R10 control reads zero");
        wr(17'h03064, 32'h100);
        rd(17'h03020, 32'h0, "R7 queue reset cfg");
        rd(17'h03030, 32'h0, "R7 queue reset len");
        rd(17'h03028, 32'h0, "R7 queue reset base");
        rd(17'h03024, 32'h8000_0000, "R7 queue reset status");

        // R4 oversize doorbell on queue 7
        wr(17'h08030, 32'd16);
        wr(17'h08038, 32'h00FF_FFFF);
        rd(17'h0803C, 32'd15, "R4 clamped tail");
        rd(17'h08024, 32'hA000_000F, "R4 status");
        // R6 head wraps to zero
        wr(17'h08020, 32'h0003_0000);
        for (int k = 0; k < 15; k++) pop(4'd7, 1'b1, "R6 grant q7");
        rd(17'h08034, 32'd15, "R6 head at end");
        wr(17'h08038, 32'h1);
        rd(17'h0803C, 32'h0, "R3 tail wraps to zero");
        pop(4'd7, 1'b1, "R6 last slot");
        rd(17'h08034, 32'h0, "R6 head wraps to zero");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule